// File: doc/BRIEF.md
# DMA Event Status and Interrupt Mask Register

This block keeps the 32-bit status word of a multi-channel DMA controller. The low half holds sticky event flags: one flag for each transfer channel, raised by a one-cycle pulse from that channel when it completes or faults, and a separate flag raised by a bus-error pulse. The high half holds one interrupt-enable bit for each flag position. When any flag and its enable bit are both 1, a registered interrupt request goes high.

Software reads the whole word back on the register bus. A write to the word clears each low-half flag whose data bit is 1. For the high half, each data bit that is 1 inverts the matching enable bit, so enable bits are never set directly. A second, otherwise unused address decodes as an alias of the status address, and a write there has the same effect.

Top module: `dma_evt_stat`

## Requirements
- R1: After reset, every flag bit, every enable bit, the read word and the interrupt output are 0.
- R2: A pulse on channel input bit c (c = 0..9) sets flag bit c in the cycle after the pulse. The flag then stays set until software clears it.
- R3: A pulse on the bus-error input sets flag bit 15 in the cycle after the pulse. No other flag changes.
- R4: A write to the status address with data bit n set (n = 0..15) clears flag n. Flags whose data bit is 0 are unchanged.
- R5: A write with data bit n set (n = 16..31) inverts enable bit n. Enable bits whose data bit is 0 are unchanged.
- R6: A write to the alias address clears flags and inverts enable bits exactly as a write to the status address does. A write to any other address changes nothing.
- R7: When a set pulse and a write that clears the same flag arrive in the same cycle, the flag ends up set.
- R8: The read data is combinational from the stored state: flags in bits 15..0 and enable bits in bits 31..16. Flag bits 10..14 always read 0.
- R9: The interrupt output equals the OR, over bit positions, of (flag AND enable). It uses the stored state of the previous cycle, so it is delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_done_i | input | 10 | One set pulse for each channel |
| bus_err_i | input | 1 | Bus-error set pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Status word: flags low, enable bits high |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Set pulses and writes both show up on the read word one clock edge after they are applied. The interrupt output lags the read word by one more edge, so it is due two edges after the stimulus. The bench applies each stimulus, waits one edge, and samples the read word on the falling edge. It compares the interrupt output one edge later against a reference model value taken from the previous cycle.

// File: rtl/dma_evt_stat_pkg.sv
package dma_evt_stat_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned N_CHAN  = 10;
  localparam int unsigned BERR_POS = 15;
  localparam int unsigned ADDR_W  = 8;

  // Set has priority: keep old, drop cleared, then add set
  function automatic logic [HALF_W-1:0] next_flags(
    input logic [HALF_W-1:0] cur,
    input logic [HALF_W-1:0] clr,
    input logic [HALF_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [HALF_W-1:0] next_mask(
    input logic [HALF_W-1:0] cur,
    input logic [HALF_W-1:0] flip);
    return cur ^ flip;
  endfunction

  function automatic logic any_pending(
    input logic [HALF_W-1:0] flags,
    input logic [HALF_W-1:0] mask);
    return |(flags & mask);
  endfunction
endpackage

// File: rtl/dma_evt_stat_dec.sv
module dma_evt_stat_dec #(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 8'hF0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              hit_o
);
  always_comb begin
    hit_o = wr_en_i && ((wr_addr_i == STAT_ADDR) || (wr_addr_i == ALIAS_ADDR));
  end
endmodule

// File: rtl/dma_evt_stat_flags.sv
module dma_evt_stat_flags
  import dma_evt_stat_pkg::*;
#(
  parameter int unsigned NCH  = N_CHAN,
  parameter int unsigned BPOS = BERR_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_done_i,
  input  logic              bus_err_i,
  input  logic              hit_i,
  input  logic [HALF_W-1:0] clr_data_i,
  output logic [HALF_W-1:0] flags_o,
  output logic [HALF_W-1:0] set_vec_o,
  output logic [HALF_W-1:0] clr_vec_o
);
  always_comb begin
    set_vec_o = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (i < NCH) set_vec_o[i] = chan_done_i[i];
    end
    set_vec_o[BPOS] = bus_err_i;
    clr_vec_o = hit_i ? clr_data_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= next_flags(flags_o, clr_vec_o, set_vec_o);
  end
endmodule

// File: rtl/dma_evt_stat_mask.sv
module dma_evt_stat_mask
  import dma_evt_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [HALF_W-1:0] flip_data_i,
  output logic [HALF_W-1:0] mask_o
);
  logic [HALF_W-1:0] flip;
  assign flip = hit_i ? flip_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= next_mask(mask_o, flip);
  end
endmodule

// File: rtl/dma_evt_stat.sv
module dma_evt_stat
  import dma_evt_stat_pkg::*;
#(
  parameter int unsigned NCH = N_CHAN,
  parameter int unsigned AW  = ADDR_W,
  parameter logic [AW-1:0] STAT_ADDR  = 8'h10,
  parameter logic [AW-1:0] ALIAS_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_done_i,
  input  logic              bus_err_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic              wr_hit;
  logic [HALF_W-1:0] flags, mask, set_vec, clr_vec;

  dma_evt_stat_dec #(.ADDR_W(AW), .STAT_ADDR(STAT_ADDR), .ALIAS_ADDR(ALIAS_ADDR)) u_dec (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .hit_o(wr_hit));

  dma_evt_stat_flags #(.NCH(NCH), .BPOS(BERR_POS)) u_flags (
    .clk(clk), .rst_n(rst_n), .chan_done_i(chan_done_i), .bus_err_i(bus_err_i),
    .hit_i(wr_hit), .clr_data_i(wr_data_i[HALF_W-1:0]),
    .flags_o(flags), .set_vec_o(set_vec), .clr_vec_o(clr_vec));

  dma_evt_stat_mask u_mask (
    .clk(clk), .rst_n(rst_n), .hit_i(wr_hit),
    .flip_data_i(wr_data_i[WORD_W-1:HALF_W]), .mask_o(mask));

  assign rd_data_o = {mask, flags};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_pending(flags, mask);
  end
endmodule

// File: rtl/dma_evt_stat_chk.sv
module dma_evt_stat_chk
  import dma_evt_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] set_vec,
  input logic [HALF_W-1:0] clr_vec,
  input logic              wr_hit,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              irq_o
);
  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((rd_data_o[HALF_W-1:0] & $past(set_vec)) == $past(set_vec)));
  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((rd_data_o[HALF_W-1:0] & $past(set_vec & clr_vec)) != '0));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(rd_data_o[WORD_W-1:HALF_W]));
  // R5
  mask_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (rd_data_o[WORD_W-1:HALF_W] ==
                ($past(rd_data_o[WORD_W-1:HALF_W]) ^ $past(wr_data_i[WORD_W-1:HALF_W]))));
  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(rd_data_o[WORD_W-1:HALF_W] & rd_data_o[HALF_W-1:0]))));
  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[14:10] == 5'b0);
endmodule

bind dma_evt_stat dma_evt_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .wr_hit(wr_hit),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o));

// File: tb/dma_evt_stat_tb.sv
module dma_evt_stat_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  chan = '0;
  logic        berr = 0;
  logic        wen = 0;
  logic [7:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd;
  logic        irq;

  int errs = 0, checks = 0;
  logic [15:0] m_flag = '0, m_mask = '0;
  logic        m_irq = 0;

  always #5 clk = ~clk;

  dma_evt_stat dut_i (.clk(clk), .rst_n(rst_n), .chan_done_i(chan), .bus_err_i(berr),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata), .rd_data_o(rd), .irq_o(irq));

  function automatic logic [31:0] model_step(input logic [15:0] f, input logic [15:0] m,
      input logic [9:0] c, input logic b, input logic w, input logic [7:0] a, input logic [31:0] d);
    logic hit;
    logic [15:0] s;
    hit = w && (a == 8'h10 || a == 8'hF0);
    s = {b, 5'b0, c};
    if (hit) begin
      f = f & ~d[15:0];
      m = m ^ d[31:16];
    end
    f = f | s;
    return {m, f};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, advance model, check read word and irq
  task automatic cyc(input string req, input logic [9:0] c, input logic b,
      input logic w, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] nx;
    chan = c; berr = b; wen = w; waddr = a; wdata = d;
    nx = model_step(m_flag, m_mask, c, b, w, a, d);
    @(posedge clk);
    m_irq = |(m_flag & m_mask);
    m_flag = nx[15:0]; m_mask = nx[31:16];
    @(negedge clk);
    chan = '0; berr = 0; wen = 0;
    check(req, rd, {m_mask, m_flag});
    check("R9", {31'b0, irq}, {31'b0, m_irq});
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    join_none
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", {rd[31:1], irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", rd, 32'h0);
    cyc("R2", 10'h201, 0, 0, 0, 0);
    cyc("R3", 0, 1, 0, 0, 0);
    cyc("R5", 0, 0, 1, 8'h10, 32'h8001_0000);
    cyc("R5", 0, 0, 1, 8'h10, 32'h8000_0000);
    cyc("R4", 0, 0, 1, 8'h10, 32'h0000_0001);
    cyc("R6", 0, 0, 1, 8'hF0, 32'h0200_0200);
    cyc("R6", 0, 0, 1, 8'h11, 32'hFFFF_FFFF);
    cyc("R7", 10'h004, 0, 1, 8'h10, 32'h0000_0004);
    cyc("R7", 0, 1, 1, 8'hF0, 32'h0000_8000);
    cyc("R8", 0, 0, 1, 8'h10, 32'h0000_7C00);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: a = 8'h10; 1: a = 8'hF0; 2: a = 8'h20; default: a = $urandom;
      endcase
      cyc("R4", (($urandom % 4) == 0) ? 10'($urandom) : 10'h0, ($urandom % 8) == 0,
          ($urandom % 2) == 1, a, $urandom);
    end
    cyc("R9", 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule